// File: doc/BRIEF.md
# Byte-Lane Data Memory

This block is the data store of a small 32-bit processor. It holds 4 KB as 1024 words of 32 bits. The load/store path gives it a byte address, store data, a store enable and a 2-bit access type. It supports full-word, halfword and byte transfers. On a store, only the byte lanes that the access type and the low address bits select are written. On a load, the selected lane is pulled out of the addressed word and widened to 32 bits, with either sign extension or zero extension.

Reads are combinational from the current address and access type. Writes and the synchronous clear happen on the rising clock edge. The pins are plain control and data pins with no valid/ready pair. The block accepts a new access every cycle and never stalls, so there is no back-pressure to describe. A request is taken on every clock edge where the store enable is high. Misaligned accesses raise no exception: address bit 0 is ignored for halfwords, and bits [1:0] are ignored for words.

Top module: `bytelane_dmem`

## Requirements
- R1: The word index is byte address bits [11:2]. Address bits above bit 11 are ignored, so two addresses that differ only there reach the same word.
- R2: When reset is high at a rising clock edge, every word is cleared to zero. The reset is synchronous.
- R3: Storage changes only at a rising clock edge where the store enable is high. With the enable low, the data on the write input has no effect.
- R4: Access type 2'b00 is a full word. A word store writes all 32 bits, and a word load returns the whole word unchanged.
- R5: Access type 2'b10 or 2'b11 on a store writes write-data bits [7:0] into the lane chosen by address bits [1:0], in little-endian order (lane 0 is bits [7:0]). The other three bytes of the word are left as they were.
- R6: Access type 2'b01 on a store writes write-data bits [15:0] into the lower half of the word when address bit 1 is 0, and into the upper half when it is 1. Address bit 0 is ignored.
- R7: Access type 2'b10 on a load returns the byte lane chosen by address bits [1:0], sign-extended to 32 bits.
- R8: Access type 2'b11 on a load returns the byte lane chosen by address bits [1:0], zero-extended to 32 bits.
- R9: Access type 2'b01 on a load returns the half chosen by address bit 1, always sign-extended to 32 bits.
- R10: The read path is combinational. Right after a store edge, the same address shows the updated word with no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear of the whole array |
| addr | input | 32 | Byte address from the address adder |
| wdata | input | 32 | Store data, taken from the low bits for sub-word stores |
| we | input | 1 | Store enable |
| acc | input | 2 | Access type: 00 word, 01 half, 10 signed byte, 11 unsigned byte |
| rdata | output | 32 | Extracted and extended load result |

## Verification
A wrong lane mask stays hidden in storage and only shows when the corrupted byte is loaded again. The bench therefore fills a word with a known pattern, stores one lane, and reads back every neighbouring lane at once. A wrong extension or lane select shows on `rdata` in the same cycle as the load, because there is no register on the read path. Wrong index decoding or aliasing shows on the first read through the alias address. A faulty clear shows on the first load after reset.

// File: rtl/bytelane_dmem_pkg.sv
package bytelane_dmem_pkg;
  typedef enum logic [1:0] {
    ACC_WORD   = 2'b00,
    ACC_HALF   = 2'b01,
    ACC_BYTE_S = 2'b10,
    ACC_BYTE_U = 2'b11
  } dm_acc_e;
endpackage

// File: rtl/dmem_store_lanes.sv
module dmem_store_lanes
  import bytelane_dmem_pkg::*;
#(
  parameter int LANES = 4
) (
  input  dm_acc_e          acc,
  input  logic [1:0]       lo,
  input  logic [8*LANES-1:0] wdata,
  output logic [LANES-1:0] be,
  output logic [8*LANES-1:0] wbus
);
  localparam int HALF_LANES = LANES / 2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      unique case (acc)
        ACC_WORD:   be[g] = 1'b1;
        ACC_HALF:   be[g] = ((g / HALF_LANES) == int'(lo[1]));
        default:    be[g] = (lo == 2'(g));
      endcase
    end
  end

  always_comb begin
    unique case (acc)
      ACC_WORD: wbus = wdata;
      ACC_HALF: wbus = {HALF_LANES{wdata[15:0]}};
      default:  wbus = {LANES{wdata[7:0]}};
    endcase
  end

  always_comb begin
    // R5
    if (acc == ACC_BYTE_S || acc == ACC_BYTE_U)
      byte_one_lane_chk: assert ($countones(be) == 1);
    // R6
    if (acc == ACC_HALF)
      half_pair_chk: assert (be == 4'b0011 || be == 4'b1100);
  end
endmodule

// File: rtl/dmem_word_array.sv
module dmem_word_array #(
  parameter int IDX_W = 10,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic [LANES-1:0]   be,
  input  logic [8*LANES-1:0] wbus,
  output logic [8*LANES-1:0] rd_word
);
  localparam int DEPTH = 1 << IDX_W;

  logic [8*LANES-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (we) begin
      for (int l = 0; l < LANES; l++)
        if (be[l]) mem[idx][8*l +: 8] <= wbus[8*l +: 8];
    end
  end

  assign rd_word = mem[idx];

  // R2
  rst_clear_chk: assert property (@(posedge clk) rst |=> rd_word == '0);

  // R3
  hold_no_we_chk: assert property (@(posedge clk)
    (!we && !rst) |=> (idx != $past(idx)) || (rd_word == $past(rd_word)));
endmodule

// File: rtl/dmem_load_lanes.sv
module dmem_load_lanes
  import bytelane_dmem_pkg::*;
(
  input  dm_acc_e     acc,
  input  logic [1:0]  lo,
  input  logic [31:0] word,
  output logic [31:0] rdata
);
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  assign byte_sel = word[8*lo +: 8];
  assign half_sel = lo[1] ? word[31:16] : word[15:0];

  always_comb begin
    unique case (acc)
      ACC_WORD:   rdata = word;
      ACC_HALF:   rdata = {{16{half_sel[15]}}, half_sel};
      ACC_BYTE_S: rdata = {{24{byte_sel[7]}}, byte_sel};
      default:    rdata = {24'h0, byte_sel};
    endcase
  end

  always_comb begin
    // R7
    if (acc == ACC_BYTE_S)
      sbyte_ext_chk: assert (rdata[31:8] == {24{rdata[7]}});
    // R8
    if (acc == ACC_BYTE_U)
      ubyte_zero_chk: assert (rdata[31:8] == 24'h0);
    // R9
    if (acc == ACC_HALF)
      half_ext_chk: assert (rdata[31:16] == {16{rdata[15]}});
  end
endmodule

// File: rtl/bytelane_dmem.sv
module bytelane_dmem
  import bytelane_dmem_pkg::*;
#(
  parameter int BYTE_AW = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  input  logic        we,
  input  logic [1:0]  acc,
  output logic [31:0] rdata
);
  localparam int LANES = 4;
  localparam int IDX_W = BYTE_AW - 2;

  dm_acc_e            acc_t;
  logic [IDX_W-1:0]   idx;
  logic [LANES-1:0]   be;
  logic [31:0]        wbus;
  logic [31:0]        word;
  logic               unused_hi;

  assign acc_t     = dm_acc_e'(acc);
  assign idx       = addr[BYTE_AW-1:2];
  assign unused_hi = ^addr[31:BYTE_AW];

  dmem_store_lanes #(.LANES(LANES)) u_store (
    .acc(acc_t), .lo(addr[1:0]), .wdata(wdata), .be(be), .wbus(wbus)
  );

  dmem_word_array #(.IDX_W(IDX_W), .LANES(LANES)) u_array (
    .clk(clk), .rst(rst), .we(we), .idx(idx), .be(be), .wbus(wbus),
    .rd_word(word)
  );

  dmem_load_lanes u_load (
    .acc(acc_t), .lo(addr[1:0]), .word(word), .rdata(rdata)
  );

  // R10
  word_store_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (we && acc == 2'b00) |=> (addr != $past(addr)) || (acc != 2'b00)
      || (rdata == $past(wdata)));
endmodule

// File: tb/bytelane_dmem_bench.sv
module bytelane_dmem_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [1:0]  acc = 2'b00;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bytelane_dmem u_bytelane_dmem (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .acc(acc),
    .rdata(rdata)
  );

  task automatic check(input string req, input logic [31:0] exp);
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, rdata, exp);
    end
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [1:0] t);
    @(negedge clk);
    addr = a; wdata = d; acc = t; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic load(input logic [31:0] a, input logic [1:0] t,
                      input string req, input logic [31:0] exp);
    @(negedge clk);
    addr = a; acc = t;
    #1 check(req, exp);
  endtask

  task automatic t_reset();
    store(32'h40, 32'hDEADBEEF, 2'b00);
    load(32'h40, 2'b00, "R4", 32'hDEADBEEF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    load(32'h40, 2'b00, "R2", 32'h0);
    load(32'hFFC, 2'b00, "R2", 32'h0);
  endtask

  task automatic t_no_we();
    @(negedge clk);
    addr = 32'h80; wdata = 32'hFFFFFFFF; acc = 2'b00; we = 1'b0;
    @(negedge clk);
    load(32'h80, 2'b00, "R3", 32'h0);
  endtask

  task automatic t_bytes();
    store(32'h100, 32'h11223344, 2'b00);
    store(32'h102, 32'hAABBCCDD, 2'b10);
    load(32'h100, 2'b00, "R5", 32'h11DD3344);
    store(32'h103, 32'h00000099, 2'b11);
    load(32'h100, 2'b00, "R5", 32'h99DD3344);
    load(32'h102, 2'b10, "R7", 32'hFFFFFFDD);
    load(32'h100, 2'b10, "R7", 32'h00000044);
    load(32'h102, 2'b11, "R8", 32'h000000DD);
    load(32'h103, 2'b11, "R8", 32'h00000099);
  endtask

  task automatic t_halves();
    store(32'h200, 32'h0, 2'b00);
    store(32'h202, 32'h1234ABCD, 2'b01);
    load(32'h200, 2'b00, "R6", 32'hABCD0000);
    store(32'h201, 32'h00007777, 2'b01);
    load(32'h200, 2'b00, "R6", 32'hABCD7777);
    load(32'h202, 2'b01, "R9", 32'hFFFFABCD);
    load(32'h200, 2'b01, "R9", 32'h00007777);
  endtask

  task automatic t_alias();
    store(32'hF0001010, 32'hCAFEF00D, 2'b00);
    load(32'h00000010, 2'b00, "R1", 32'hCAFEF00D);
    load(32'h00000014, 2'b00, "R1", 32'h0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    addr = 32'h300; wdata = 32'h5A5A1234; acc = 2'b00; we = 1'b1;
    @(posedge clk);
    #1 check("R10", 32'h5A5A1234);
    @(negedge clk); we = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    load(32'h0, 2'b00, "R2", 32'h0);
    t_reset();
    t_no_we();
    t_bytes();
    t_halves();
    t_alias();
    t_same_cycle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule